// File: doc/BRIEF.md
# I2C Channel Register Front End

This block is the register-side front end of one I2C controller channel. Software reaches it over a simple synchronous register bus with an address, a write strobe, write data, a read strobe and read data. Behind it sits a separate bit-level bus engine, which is not part of this block. The engine reports protocol events as single-cycle pulses and shows the live state of the bus lines. The block latches those events into a flag register, buffers one transmit byte and one received byte, and raises an interrupt for any flag whose enable bit is set.

The flag register combines three ways of clearing a flag:

- Six event flags are cleared by writing one to their bit.
- The receive-full flag clears as a side effect of reading the receive register.
- The transmit-empty flag clears as a side effect of writing the transmit register.

Four live status bits are also visible in the flag register. They are sampled when the register is read and hold no state.

A write to the transmit register while it is still full is refused. The held byte is kept and a sticky overwrite-error output is raised.

Top module: `i2c_regfront`

## Requirements
- R1: After hardware reset `rst`, all of the following are 0: every flag, the interrupt-enable register, the transmit and receive bytes, `rdata`, `irq` and `ovr_err`.
- R2: Register offsets are 0 for transmit data, 1 for receive data, 2 for flags and 3 for interrupt enable. `rdata` is registered: it shows the addressed register's value from before the read cycle, one cycle after `rd`, and holds between reads. Data registers read bits 15..8 as 0.
- R3: The flag register reads with these bit positions:
  - bit 12: SDA low
  - bit 11: SCL low
  - bit 10: bus busy
  - bit 9: transmitting
  - bit 7: byte end
  - bit 6: general call
  - bit 5: NACK
  - bit 4: stop
  - bit 3: start
  - bit 2: error
  - bit 1: receive full
  - bit 0: transmit empty

  Bits 15..13 and bit 8 read as 0. Bits 12..9 are the live inputs as sampled in the read cycle.
- R4: A pulse on `ev_set[i]` sets flag i, and the flag reads as 1 from the next cycle on.
- R5: Writing the flag register clears each of flags 7..2 whose write-data bit is 1. Flags whose write-data bit is 0 are unchanged. Flags 1 and 0 are never changed by such a write.
- R6: `ev_set[1]` loads `rx_byte` into the receive register. A read of offset 1 clears flag 1.
- R7: A write to offset 0 while flag 0 is 1 loads `wdata[7:0]` into `tx_byte` and clears flag 0.
- R8: A write to offset 0 while flag 0 is 0 leaves `tx_byte` unchanged and leaves flag 0 at 0. It sets `ovr_err`, which stays 1 until hardware reset.
- R9: When a set pulse and a clear action hit the same flag in the same cycle, the flag ends at 1.
- R10: `soft_rst` clears flags 7..0 in the next cycle and overrides set pulses in that cycle. It leaves the data registers, the interrupt enables and `ovr_err` unchanged.
- R11: Interrupt-enable bits 7..0 are written at offset 3 and read back there. `irq` is 1 exactly when some flag and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Software reset of the latched flags |
| addr | input | 2 | Register offset |
| wr | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rd | input | 1 | Read strobe |
| rdata | output | 16 | Registered read data |
| ev_set | input | 8 | Event pulses from the engine, one per flag bit |
| rx_byte | input | 8 | Received byte, valid with `ev_set[1]` |
| sda_low | input | 1 | Live: SDA line is low |
| scl_low | input | 1 | Live: SCL line is low |
| busy | input | 1 | Live: bus busy |
| xmit | input | 1 | Live: channel is transmitting |
| tx_byte | output | 8 | Held transmit byte for the engine |
| ovr_err | output | 1 | Sticky transmit-overwrite error |
| irq | output | 1 | Enable-qualified interrupt |

## Verification
A wrong flag state is visible on `irq` in the same cycle once its enable bit is set. It also shows up in `rdata` one cycle after a read of offset 2. A lost transmit-guard check shows up directly on `tx_byte` and `ovr_err` in the cycle after the offending write. A wrong side-effect clear or a wrong set-versus-clear priority stays hidden until the next flag read or the next `irq` change. For that reason the reference model is compared with `rdata`, `irq`, `tx_byte` and `ovr_err` on every cycle, and flag reads are placed directly after each such collision.

// File: rtl/i2c_regfront_pkg.sv
package i2c_regfront_pkg;
  localparam int FLAG_N   = 8;
  localparam int LIVE_LSB = 9;
  localparam int FLG_TBE  = 0;
  localparam int FLG_RBF  = 1;
  localparam int W1C_LSB  = 2;

  typedef enum logic [1:0] {
    REG_TXD = 2'd0,
    REG_RXD = 2'd1,
    REG_FLG = 2'd2,
    REG_IEN = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         srst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || srst)  flags[i] <= 1'b0;
      else if (set[i])  flags[i] <= 1'b1;
      else if (clr[i])  flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_data_regs.sv
module i2c_data_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_we,
  input  logic              tx_room,
  input  logic [DATA_W-1:0] tx_din,
  input  logic              rx_we,
  input  logic [DATA_W-1:0] rx_din,
  output logic [DATA_W-1:0] tx_q,
  output logic [DATA_W-1:0] rx_q,
  output logic              ovr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= '0;
      rx_q  <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (tx_we && tx_room)  tx_q  <= tx_din;
      if (tx_we && !tx_room) ovr_q <= 1'b1;
      if (rx_we)             rx_q  <= rx_din;
    end
  end
endmodule

// File: rtl/i2c_rd_mux.sv
module i2c_rd_mux
  import i2c_regfront_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int DATA_W = 8,
  parameter int N      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] tx_q,
  input  logic [DATA_W-1:0] rx_q,
  input  logic [N-1:0]      flags,
  input  logic [N-1:0]      ien,
  input  logic [3:0]        live,
  output logic [BUS_W-1:0]  rdata
);
  logic [BUS_W-1:0] rd_n;

  always_comb begin
    rd_n = '0;
    unique case (sel)
      REG_TXD: rd_n[DATA_W-1:0] = tx_q;
      REG_RXD: rd_n[DATA_W-1:0] = rx_q;
      REG_FLG: begin
        rd_n[N-1:0]                = flags;
        rd_n[LIVE_LSB+3:LIVE_LSB] = live;
      end
      REG_IEN: rd_n[N-1:0] = ien;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_n;
  end
endmodule

// File: rtl/i2c_regfront.sv
module i2c_regfront
  import i2c_regfront_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [1:0]        addr,
  input  logic              wr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              rd,
  output logic [BUS_W-1:0]  rdata,
  input  logic [FLAG_N-1:0] ev_set,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              sda_low,
  input  logic              scl_low,
  input  logic              busy,
  input  logic              xmit,
  output logic [DATA_W-1:0] tx_byte,
  output logic              ovr_err,
  output logic              irq
);
  localparam int W1C_N = FLAG_N - W1C_LSB;

  reg_sel_e          sel;
  logic [FLAG_N-1:0] flag_q, flag_clr, ien_q;
  logic [DATA_W-1:0] rx_q;
  logic              tx_wr, flg_wr;
  logic              unused_hi;

  assign sel       = reg_sel_e'(addr);
  assign tx_wr     = wr && (sel == REG_TXD);
  assign flg_wr    = wr && (sel == REG_FLG);
  assign unused_hi = ^wdata[BUS_W-1:FLAG_N];

  assign flag_clr[FLAG_N-1:W1C_LSB] = wdata[FLAG_N-1:W1C_LSB] & {W1C_N{flg_wr}};
  assign flag_clr[FLG_RBF]          = rd && (sel == REG_RXD);
  assign flag_clr[FLG_TBE]          = tx_wr;

  always_ff @(posedge clk) begin
    if (rst)                      ien_q <= '0;
    else if (wr && sel == REG_IEN) ien_q <= wdata[FLAG_N-1:0];
  end

  assign irq = |(flag_q & ien_q);

  i2c_flag_bank #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst(rst), .srst(soft_rst),
    .set(ev_set), .clr(flag_clr), .flags(flag_q)
  );

  i2c_data_regs #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst),
    .tx_we(tx_wr), .tx_room(flag_q[FLG_TBE]), .tx_din(wdata[DATA_W-1:0]),
    .rx_we(ev_set[FLG_RBF]), .rx_din(rx_byte),
    .tx_q(tx_byte), .rx_q(rx_q), .ovr_q(ovr_err)
  );

  i2c_rd_mux #(.BUS_W(BUS_W), .DATA_W(DATA_W), .N(FLAG_N)) u_rd (
    .clk(clk), .rst(rst), .rd(rd), .sel(sel),
    .tx_q(tx_byte), .rx_q(rx_q), .flags(flag_q), .ien(ien_q),
    .live({sda_low, scl_low, busy, xmit}), .rdata(rdata)
  );
endmodule

// File: rtl/i2c_regfront_chk.sv
module i2c_regfront_chk (
  input logic        clk,
  input logic        rst,
  input logic        soft_rst,
  input logic [1:0]  addr,
  input logic        wr,
  input logic        rd,
  input logic [15:0] wdata,
  input logic [7:0]  ev_set,
  input logic [7:0]  flag_q,
  input logic [7:0]  ien_q,
  input logic [7:0]  tx_byte,
  input logic        ovr_err,
  input logic        irq,
  input logic [15:0] rdata
);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (ev_set != 8'h00 && !soft_rst) |=> ((flag_q & $past(ev_set)) == $past(ev_set)));

  p_soft_clear_r10: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (flag_q == 8'h00));

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovr_err |=> ovr_err);

  p_tx_guard_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 2'd0 && !flag_q[0]) |=> ($stable(tx_byte) && ovr_err));

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (ien_q == 8'h00) |-> !irq);

  p_w1c_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 2'd2 && wdata[7:2] == 6'd0 && ev_set == 8'h00 && !soft_rst)
      |=> (flag_q[7:2] == $past(flag_q[7:2])));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd && addr != 2'd2) |=> (rdata[15:8] == 8'h00));
endmodule

bind i2c_regfront i2c_regfront_chk u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .addr(addr), .wr(wr), .rd(rd),
  .wdata(wdata), .ev_set(ev_set), .flag_q(flag_q), .ien_q(ien_q),
  .tx_byte(tx_byte), .ovr_err(ovr_err), .irq(irq), .rdata(rdata)
);

// File: tb/i2c_regfront_test.sv
module i2c_regfront_test;
  logic        clk = 1'b0, rst = 1'b1, soft_rst = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  ev_set = '0, rx_byte = '0;
  logic        sda_low = 1'b0, scl_low = 1'b0, busy = 1'b0, xmit = 1'b0;
  logic [7:0]  tx_byte;
  logic        ovr_err, irq;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  i2c_regfront uut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .addr(addr), .wr(wr),
    .wdata(wdata), .rd(rd), .rdata(rdata), .ev_set(ev_set), .rx_byte(rx_byte),
    .sda_low(sda_low), .scl_low(scl_low), .busy(busy), .xmit(xmit),
    .tx_byte(tx_byte), .ovr_err(ovr_err), .irq(irq)
  );

  // behavioural reference model
  logic [7:0]  m_flags, m_ien, m_tx, m_rx;
  logic [15:0] m_rdata;
  logic        m_ovr;

  always @(posedge clk) begin
    logic [7:0] f, clr;
    if (rst) begin
      m_flags = 0; m_ien = 0; m_tx = 0; m_rx = 0; m_rdata = 0; m_ovr = 0;
    end else begin
      f = m_flags;
      if (rd) begin
        case (addr)
          2'd0: m_rdata = {8'h00, m_tx};
          2'd1: m_rdata = {8'h00, m_rx};
          2'd2: m_rdata = {3'b000, sda_low, scl_low, busy, xmit, 1'b0, f};
          default: m_rdata = {8'h00, m_ien};
        endcase
      end
      clr = 8'h00;
      if (wr && addr == 2'd2) clr = wdata[7:0] & 8'hFC;
      if (rd && addr == 2'd1) clr[1] = 1'b1;
      if (wr && addr == 2'd0) clr[0] = 1'b1;
      for (int i = 0; i < 8; i++)
        m_flags[i] = soft_rst ? 1'b0 : ev_set[i] ? 1'b1 : clr[i] ? 1'b0 : f[i];
      if (wr && addr == 2'd3) m_ien = wdata[7:0];
      if (wr && addr == 2'd0) begin
        if (f[0]) m_tx = wdata[7:0];
        else      m_ovr = 1'b1;
      end
      if (ev_set[1]) m_rx = rx_byte;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(rdata == m_rdata, "model rdata R2", rdata, m_rdata);
      chk(irq == |(m_flags & m_ien), "model irq R11", irq, |(m_flags & m_ien));
      chk(tx_byte == m_tx, "model tx R7", tx_byte, m_tx);
      chk(ovr_err == m_ovr, "model ovr R8", ovr_err, m_ovr);
    end
  end

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      chk(1'b0, "watchdog", cyc, 20000);
      finish_up();
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; wdata = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk); ev_set = e;
    @(negedge clk); ev_set = 0;
  endtask

  logic [15:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(irq == 0 && tx_byte == 0 && ovr_err == 0 && rdata == 0, "R1 outputs",
        {irq, ovr_err, tx_byte}, 0);
    bus_rd(2'd2, v); chk(v == 16'h0000, "R1 flags", v, 0);
    bus_rd(2'd3, v); chk(v == 16'h0000, "R1 ien", v, 0);

    pulse(8'h01);
    bus_rd(2'd2, v); chk(v == 16'h0001, "R4 tbe set", v, 16'h0001);
    bus_wr(2'd0, 16'h01A5);
    chk(tx_byte == 8'hA5, "R7 tx load", tx_byte, 8'hA5);
    bus_rd(2'd2, v); chk(v == 16'h0000, "R7 tbe clear", v, 0);
    bus_wr(2'd0, 16'h003C);
    chk(tx_byte == 8'hA5, "R8 tx kept", tx_byte, 8'hA5);
    chk(ovr_err == 1'b1, "R8 ovr set", ovr_err, 1);
    bus_rd(2'd2, v); chk(v == 16'h0000, "R8 tbe stays 0", v, 0);

    rx_byte = 8'h5A; pulse(8'h02);
    bus_rd(2'd2, v); chk(v == 16'h0002, "R6 rbf set", v, 16'h0002);
    bus_rd(2'd1, v); chk(v == 16'h005A, "R6 rx data", v, 16'h005A);
    bus_rd(2'd2, v); chk(v == 16'h0000, "R6 rbf cleared by read", v, 0);

    pulse(8'hFC);
    bus_rd(2'd2, v); chk(v == 16'h00FC, "R4 event flags", v, 16'h00FC);
    bus_wr(2'd2, 16'hFF00);
    bus_rd(2'd2, v); chk(v == 16'h00FC, "R5 write zero no effect", v, 16'h00FC);
    bus_wr(2'd2, 16'h0024);
    bus_rd(2'd2, v); chk(v == 16'h00D8, "R5 partial w1c", v, 16'h00D8);
    pulse(8'h03);
    bus_wr(2'd2, 16'h00FF);
    bus_rd(2'd2, v); chk(v == 16'h0003, "R5 bits 1:0 untouched", v, 16'h0003);

    // R9: set and clear collide
    @(negedge clk); wr = 1; addr = 2'd2; wdata = 16'h0010; ev_set = 8'h10;
    @(negedge clk); wr = 0; wdata = 0; ev_set = 0;
    rx_byte = 8'h77;
    @(negedge clk); rd = 1; addr = 2'd1; ev_set = 8'h02;
    @(negedge clk); rd = 0; ev_set = 0;
    chk(rdata == 16'h005A, "R2 pre-update rx read", rdata, 16'h005A);
    bus_rd(2'd2, v); chk(v == 16'h0013, "R9 set wins", v, 16'h0013);

    bus_wr(2'd3, 16'hFF10);
    chk(irq == 1'b1, "R11 irq on", irq, 1);
    bus_rd(2'd3, v); chk(v == 16'h0010, "R11 ien readback", v, 16'h0010);
    bus_wr(2'd2, 16'h0010);
    chk(irq == 1'b0, "R11 irq off", irq, 0);

    sda_low = 1; busy = 1;
    bus_rd(2'd2, v); chk(v == 16'h1403, "R3 live sda busy", v, 16'h1403);
    sda_low = 0; busy = 0; scl_low = 1; xmit = 1;
    bus_rd(2'd2, v); chk(v == 16'h0A03, "R3 live scl xmit", v, 16'h0A03);

    @(negedge clk); soft_rst = 1; ev_set = 8'h80;
    @(negedge clk); soft_rst = 0; ev_set = 0;
    bus_rd(2'd2, v); chk(v == 16'h0A00, "R10 flags cleared", v, 16'h0A00);
    chk(tx_byte == 8'hA5 && ovr_err == 1'b1, "R10 data kept", {ovr_err, tx_byte}, 9'h1A5);
    bus_rd(2'd3, v); chk(v == 16'h0010, "R10 ien kept", v, 16'h0010);

    bus_rd(2'd0, v); chk(v == 16'h00A5, "R2 tx readback", v, 16'h00A5);
    bus_rd(2'd1, v); chk(v == 16'h0077, "R2 rx readback", v, 16'h0077);
    repeat (3) @(negedge clk);
    chk(rdata == 16'h0077, "R2 rdata holds", rdata, 16'h0077);
    finish_up();
  end
endmodule